// File: doc/BRIEF.md
# Paged Packet Memory Allocator

This block keeps track of a shared packet RAM that is cut into equal pages. Software asks for packet memory by giving a byte count. The allocator turns that count into a number of whole pages. It picks the lowest packet number not in use and scans the page bitmap one page per cycle, claiming free pages until the request is met. It then publishes the packet number and sets a sticky completion flag that software can poll or use as an interrupt source.

Memory comes back in two ways. Software can issue an explicit release of a packet number. The transmit queue logic can also report a finished transmission, and when automatic return is enabled and the transmission succeeded, that packet's pages are freed. A request larger than the free space waits with a failure indication until enough pages come back. A whole-memory reset command empties everything in one cycle.

Top module: `pba_top`

## Requirements
- R1: After rst_n, free_pages equals NUM_PAGES (32), and busy, alloc_done and result_failed are 0.
- R2: An allocate command (cmd_op = 1) of N bytes takes ceil(N/256) pages, and N = 0 takes one page. free_pages falls by that amount once the allocation completes.
- R3: A completed allocation reports in result_pkt the lowest packet number that no live packet holds.
- R4: Starting from an empty RAM, an allocation needing n pages keeps busy high and alloc_done low until the n-th rising edge after the accepting edge, and at that edge alloc_done goes high and busy goes low.
- R5: While busy, release commands are ignored. While an allocation is pending, further allocate commands are ignored.
- R6: When too few pages are free, the allocation stays pending with result_failed = 1 and alloc_done = 0. It completes by itself once releases free enough pages.
- R7: A release command (cmd_op = 2) for a live packet number in cmd_pkt returns all of that packet's pages, and the number can be handed out again.
- R8: A release, whether by command or by transmit completion, that names a packet number that is not live leaves free_pages unchanged.
- R9: A tx_done_valid pulse frees packet tx_done_pkt only when both tx_done_ok and auto_release_en are 1. Otherwise it has no effect.
- R10: A reset command (cmd_op = 3) is accepted in any state. In one cycle it frees every page and clears any pending allocation, alloc_done and result_failed.
- R11: An accepted allocate command clears alloc_done on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 allocate, 2 release, 3 reset all |
| cmd_bytes | input | BYTES_W (14) | Requested byte count for allocate |
| cmd_pkt | input | PKT_W (5) | Packet number for release |
| tx_done_valid | input | 1 | Transmit completion strobe |
| tx_done_ok | input | 1 | Completed transmission succeeded |
| tx_done_pkt | input | PKT_W (5) | Packet number of the completed transmission |
| auto_release_en | input | 1 | Enables freeing on successful completion |
| busy | output | 1 | Page scan in progress |
| alloc_done | output | 1 | Sticky allocation completion flag |
| result_failed | output | 1 | Allocation waiting for free pages |
| result_pkt | output | PKT_W (5) | Packet number of the last completed allocation |
| free_pages | output | CNT_W (6) | Number of free pages |

## Verification
On every cycle the assertions check the following: alloc_done and busy are never high together, and the failure bit and the completion flag exclude each other. The free count cannot grow during a scan unless a transmit release or a reset arrives, and after a reset command every page is free. The owner table also checks that releasing a packet number that is not live changes nothing. Other behaviour can only be shown by the bench's scenarios: the page rounding, the choice of the lowest packet number, the exact scan latency, a pending request finishing after a release, and the gating of automatic return. The bench compares these against a reference count model under random command mixes.

// File: rtl/pba_pkg.sv
package pba_pkg;
   typedef enum logic [1:0] {
      OP_NONE    = 2'd0,
      OP_ALLOC   = 2'd1,
      OP_RELEASE = 2'd2,
      OP_RESET   = 2'd3
   } pba_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_SCAN = 2'd2
   } pba_state_e;
endpackage

// File: rtl/pba_lowest_zero.sv
module pba_lowest_zero #(
   parameter int WIDTH = 32,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (!vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pba_owner_table.sv
module pba_owner_table #(
   parameter int NUM_PAGES = 32,
   localparam int PKT_W = $clog2(NUM_PAGES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_all,
   input  logic                 claim_en,
   input  logic [PKT_W-1:0]     claim_pkt,
   input  logic [NUM_PAGES-1:0] claim_vec,
   input  logic                 commit_en,
   input  logic [PKT_W-1:0]     commit_pkt,
   input  logic                 rel_a_en,
   input  logic [PKT_W-1:0]     rel_a_pkt,
   input  logic                 rel_b_en,
   input  logic [PKT_W-1:0]     rel_b_pkt,
   output logic [NUM_PAGES-1:0] live,
   output logic [NUM_PAGES-1:0] rel_mask
);
   logic [NUM_PAGES-1:0] row_rel [NUM_PAGES];

   for (genvar r = 0; r < NUM_PAGES; r++) begin : g_row
      logic [NUM_PAGES-1:0] own_q;
      logic                 live_q;
      logic                 hit;

      assign hit = live_q && ((rel_a_en && rel_a_pkt == PKT_W'(r)) ||
                              (rel_b_en && rel_b_pkt == PKT_W'(r)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            own_q  <= '0;
            live_q <= 1'b0;
         end else if (clr_all) begin
            own_q  <= '0;
            live_q <= 1'b0;
         end else if (hit) begin
            own_q  <= '0;
            live_q <= 1'b0;
         end else begin
            if (claim_en && claim_pkt == PKT_W'(r)) own_q <= own_q | claim_vec;
            if (commit_en && commit_pkt == PKT_W'(r)) live_q <= 1'b1;
         end
      end

      assign live[r]    = live_q;
      assign row_rel[r] = hit ? own_q : '0;
   end

   always_comb begin
      rel_mask = '0;
      for (int r = 0; r < NUM_PAGES; r++) rel_mask = rel_mask | row_rel[r];
   end

   // R8: naming a packet that is not live must leave the live set alone
   p_ghost_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_a_en && !live[rel_a_pkt] && !rel_b_en && !clr_all && !commit_en)
      |=> (live == $past(live)));
endmodule

// File: rtl/pba_top.sv
module pba_top #(
   parameter int PAGE_BYTES = 256,
   parameter int NUM_PAGES  = 32,
   localparam int PKT_W   = $clog2(NUM_PAGES),
   localparam int CNT_W   = PKT_W + 1,
   localparam int PAGE_SH = $clog2(PAGE_BYTES),
   localparam int BYTES_W = PKT_W + PAGE_SH + 1,
   localparam int NEED_W  = BYTES_W - PAGE_SH + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [BYTES_W-1:0] cmd_bytes,
   input  logic [PKT_W-1:0]   cmd_pkt,
   input  logic               tx_done_valid,
   input  logic               tx_done_ok,
   input  logic [PKT_W-1:0]   tx_done_pkt,
   input  logic               auto_release_en,
   output logic               busy,
   output logic               alloc_done,
   output logic               result_failed,
   output logic [PKT_W-1:0]   result_pkt,
   output logic [CNT_W-1:0]   free_pages
);
   import pba_pkg::*;

   initial begin
      assert (PAGE_BYTES >= 2 && (PAGE_BYTES & (PAGE_BYTES - 1)) == 0)
         else $error("PAGE_BYTES must be a power of two");
      assert (NUM_PAGES >= 2 && (NUM_PAGES & (NUM_PAGES - 1)) == 0)
         else $error("NUM_PAGES must be a power of two");
   end

   pba_state_e            state_q;
   logic [NUM_PAGES-1:0]  free_q;
   logic [PKT_W-1:0]      scan_idx_q;
   logic [NEED_W-1:0]     remain_q;
   logic [NEED_W-1:0]     need_q;
   logic [PKT_W-1:0]      cur_pkt_q;
   logic                  done_q, failed_q;
   logic [PKT_W-1:0]      res_q;

   logic op_alloc, op_rel, op_rst, tx_rel;
   logic [BYTES_W:0]      byte_sum;
   logic [NEED_W-1:0]     need_c;
   logic [NEED_W-1:0]     free_wide;
   logic                  claim, finish;
   logic [NUM_PAGES-1:0]  claim_vec, live, rel_mask;
   logic [PKT_W-1:0]      next_pkt;

   assign op_alloc = cmd_valid && cmd_op == OP_ALLOC   && state_q == ST_IDLE;
   assign op_rel   = cmd_valid && cmd_op == OP_RELEASE && state_q != ST_SCAN;
   assign op_rst   = cmd_valid && cmd_op == OP_RESET;
   assign tx_rel   = tx_done_valid && tx_done_ok && auto_release_en;

   // whole pages, with an empty request still taking one page
   assign byte_sum = {1'b0, cmd_bytes} + (BYTES_W+1)'(PAGE_BYTES - 1);
   assign need_c   = (byte_sum[BYTES_W:PAGE_SH] == '0) ? NEED_W'(1)
                                                       : byte_sum[BYTES_W:PAGE_SH];

   assign free_pages = CNT_W'($countones(free_q));
   assign free_wide  = NEED_W'(free_pages);

   assign claim     = state_q == ST_SCAN && free_q[scan_idx_q];
   assign finish    = claim && remain_q == NEED_W'(1);
   assign claim_vec = claim ? (NUM_PAGES'(1) << scan_idx_q) : '0;

   pba_lowest_zero #(.WIDTH(NUM_PAGES)) u_pick (
      .vec (live),
      .idx (next_pkt)
   );

   pba_owner_table #(.NUM_PAGES(NUM_PAGES)) u_owner (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_all    (op_rst),
      .claim_en   (claim),
      .claim_pkt  (cur_pkt_q),
      .claim_vec  (claim_vec),
      .commit_en  (finish),
      .commit_pkt (cur_pkt_q),
      .rel_a_en   (op_rel),
      .rel_a_pkt  (cmd_pkt),
      .rel_b_en   (tx_rel),
      .rel_b_pkt  (tx_done_pkt),
      .live       (live),
      .rel_mask   (rel_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q <= '1;
      end else if (op_rst) begin
         free_q <= '1;
      end else begin
         free_q <= (free_q | rel_mask) & ~claim_vec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         scan_idx_q <= '0;
         remain_q   <= '0;
         need_q     <= '0;
         cur_pkt_q  <= '0;
         done_q     <= 1'b0;
         failed_q   <= 1'b0;
         res_q      <= '0;
      end else if (op_rst) begin
         state_q  <= ST_IDLE;
         done_q   <= 1'b0;
         failed_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (op_alloc) begin
               done_q <= 1'b0;
               need_q <= need_c;
               if (need_c <= free_wide) begin
                  state_q    <= ST_SCAN;
                  scan_idx_q <= '0;
                  remain_q   <= need_c;
                  cur_pkt_q  <= next_pkt;
                  failed_q   <= 1'b0;
               end else begin
                  state_q  <= ST_PEND;
                  failed_q <= 1'b1;
               end
            end
            ST_PEND: if (need_q <= free_wide) begin
               state_q    <= ST_SCAN;
               scan_idx_q <= '0;
               remain_q   <= need_q;
               cur_pkt_q  <= next_pkt;
               failed_q   <= 1'b0;
            end
            ST_SCAN: begin
               scan_idx_q <= scan_idx_q + 1'b1;
               if (claim) remain_q <= remain_q - 1'b1;
               if (finish) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  res_q   <= cur_pkt_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy          = state_q == ST_SCAN;
   assign alloc_done    = done_q;
   assign result_failed = failed_q;
   assign result_pkt    = res_q;

   p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_done |-> !busy);

   p_fail_excl_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      result_failed |-> !alloc_done);

   p_mmu_reset_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_rst |=> (free_pages == CNT_W'(NUM_PAGES)));

   p_scan_no_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_done_valid && !(cmd_valid && cmd_op == OP_RESET))
      |=> (free_pages <= $past(free_pages)));
endmodule

// File: tb/pba_top_tb.sv
`timescale 1ns/1ps
module pba_top_tb_top;
   localparam int NP = 32;

   logic clk = 0, rst_n = 0;
   logic cmd_valid = 0, tx_done_valid = 0, tx_done_ok = 0, auto_release_en = 0;
   logic [1:0]  cmd_op = 0;
   logic [13:0] cmd_bytes = 0;
   logic [4:0]  cmd_pkt = 0, tx_done_pkt = 0;
   logic busy, alloc_done, result_failed;
   logic [4:0] result_pkt;
   logic [5:0] free_pages;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   bit m_live [NP];
   int m_pg [NP];
   int m_free;

   always #2 clk = ~clk;

   pba_top dut_i (.*);

   task automatic chk(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pages_for(input int b);
      int p = (b + 255) / 256;
      return (p == 0) ? 1 : p;
   endfunction

   function automatic int lowest_free();
      for (int i = 0; i < NP; i++) if (!m_live[i]) return i;
      return 0;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < NP; i++) begin m_live[i] = 0; m_pg[i] = 0; end
      m_free = NP;
   endtask

   task automatic send(input logic [1:0] op, input int b, input int p);
      @(negedge clk);
      cmd_valid = 1; cmd_op = op; cmd_bytes = 14'(b); cmd_pkt = 5'(p);
      @(negedge clk);
      cmd_valid = 0; cmd_op = 0;
   endtask

   task automatic tx(input bit ok, input bit au, input int p);
      @(negedge clk);
      tx_done_valid = 1; tx_done_ok = ok; auto_release_en = au; tx_done_pkt = 5'(p);
      @(negedge clk);
      tx_done_valid = 0;
   endtask

   task automatic wait_idle();
      for (int g = 0; g < 100 && busy; g++) @(negedge clk);
   endtask

   task automatic do_alloc(input int b, input string req);
      int exp_pkt = lowest_free();
      int np = pages_for(b);
      send(2'd1, b, 0);
      wait_idle();
      chk(alloc_done, 1, req);
      chk(result_pkt, exp_pkt, "R3");
      m_live[exp_pkt] = 1; m_pg[exp_pkt] = np; m_free -= np;
      chk(free_pages, m_free, "R2");
   endtask

   task automatic model_release(input int p);
      if (m_live[p]) begin m_free += m_pg[p]; m_live[p] = 0; end
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(free_pages, NP, "R1"); chk(busy, 0, "R1");
      chk(alloc_done, 0, "R1"); chk(result_failed, 0, "R1");

      // R4 latency: 3 pages from empty
      send(2'd1, 700, 0);
      chk(busy, 1, "R4"); chk(alloc_done, 0, "R4");
      repeat (2) @(negedge clk);
      chk(alloc_done, 0, "R4");
      @(negedge clk);
      chk(alloc_done, 1, "R4"); chk(busy, 0, "R4");
      chk(result_pkt, 0, "R3"); chk(free_pages, 29, "R2");
      m_live[0] = 1; m_pg[0] = 3; m_free = 29;

      // R11 new allocate clears the flag; R2 zero bytes takes one page
      send(2'd1, 0, 0);
      chk(alloc_done, 0, "R11");
      wait_idle();
      chk(result_pkt, 1, "R3"); chk(free_pages, 28, "R2");
      m_live[1] = 1; m_pg[1] = 1; m_free = 28;

      // R8 ghost release by command and by transmit
      send(2'd2, 0, 9);
      chk(free_pages, 28, "R8");
      tx(1, 1, 12);
      chk(free_pages, 28, "R8");

      // R9 gating of automatic return
      tx(1, 0, 0);
      chk(free_pages, 28, "R9");
      tx(0, 1, 0);
      chk(free_pages, 28, "R9");
      tx(1, 1, 0);
      chk(free_pages, 31, "R9");
      m_live[0] = 0; m_free = 31;

      // R10 reset command
      send(2'd3, 0, 0);
      chk(free_pages, NP, "R10");
      model_clear();

      // R5 release during scan ignored
      do_alloc(256, "R2");
      send(2'd1, 20 * 256, 0);
      chk(busy, 1, "R5");
      send(2'd2, 0, 0);
      wait_idle();
      chk(free_pages, 11, "R5");
      chk(result_pkt, 1, "R3");
      m_live[1] = 1; m_pg[1] = 20; m_free = 11;

      // R6 pending until pages come back
      do_alloc(11 * 256, "R2");
      send(2'd1, 1, 0);
      chk(result_failed, 1, "R6"); chk(alloc_done, 0, "R6"); chk(busy, 0, "R6");
      send(2'd1, 5000, 0);  // R5 ignored while pending
      chk(result_failed, 1, "R5");
      send(2'd2, 0, 1);     // R7 release packet 1
      repeat (3) @(negedge clk);
      wait_idle();
      chk(alloc_done, 1, "R6"); chk(result_failed, 0, "R6");
      chk(result_pkt, 1, "R7"); chk(free_pages, 19, "R7");

      // R10 reset clears an impossible pending request
      send(2'd1, 16000, 0);
      chk(result_failed, 1, "R6");
      send(2'd3, 0, 0);
      chk(result_failed, 0, "R10"); chk(free_pages, NP, "R10");
      chk(alloc_done, 0, "R10");
      model_clear();

      // random mix against the count model
      for (int it = 0; it < 400; it++) begin
         int act = $urandom % 3;
         int p = $urandom % NP;
         if (act == 0) begin
            int b = $urandom % 3000;
            if (pages_for(b) <= m_free) do_alloc(b, "R2");
         end else if (act == 1) begin
            send(2'd2, 0, p);
            model_release(p);
            chk(free_pages, m_free, "R7");
         end else begin
            bit ok = 1'($urandom % 2);
            bit au = 1'($urandom % 2);
            tx(ok, au, p);
            if (ok && au) model_release(p);
            chk(free_pages, m_free, "R9");
         end
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule